// File: doc/BRIEF.md
# SPI NOR Flash Image Writer

This block writes a byte image into a serial NOR flash with 24-bit addresses. It never shifts SPI bits itself. It drives a byte-wide transfer port on an external SPI master and controls that master's chip select. A run starts with a pulse on `start`, together with a start address and a byte count. First the block reads the device identity and refuses to go on if the identity is wrong. It then walks through the image one 256-byte page at a time. A sector is erased the first time the run touches it. Each page is programmed in a frame padded to its full size. After every erase and every program, the block polls the device status until the write-in-progress flag clears.

When programming is finished, the block reads the whole range back in one continuous read frame and compares it byte for byte with the image. The upstream source therefore supplies the image twice through the same valid/ready byte stream: once for programming and once for the compare. The block does not buffer the image. When the run ends, `done` rises. Two error flags tell a wrong identity apart from a failed compare. On a failed compare, `fail_addr` holds the flash address of the first differing byte.

Top module: `nor_flash_writer`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err_id`, `err_verify`, `spi_cs`, `xfer_go` and `data_ready` are all 0.
- R2: A run first holds `spi_cs` low for at least one cycle. It then sends a frame with opcode 0x9F followed by three dummy bytes, and assembles the three reply bytes with the first one as the most significant. If the value is not 0x202018, the run ends with `err_id`=1 and `done`=1. No erase or program command is sent and no image byte is taken.
- R3: Every sector erase and every page program is preceded by a frame that holds only the opcode 0x06.
- R4: The sector index is address bits 23:18, so a sector is 0x40000 bytes. Each sector that a run programs is erased exactly once, before its first page program. The record of erased sectors is cleared at every start, so a new run over the same sector erases it again.
- R5: An erase frame is 0xD8 followed by the 3 address bytes, most significant first. A program frame is 0x02, then the 3 page address bytes, then exactly 256 data bytes: the image bytes in order, then 0xFF once the image is used up. The page address then advances by 256.
- R6: After each erase or program, the block sends two-byte frames of 0x05 and a dummy byte. Each poll is its own frame. It proceeds only after a reply whose bit 0 is 0.
- R7: Verification is one frame: 0x03, the start address, then one dummy 0xFF per image byte. Each reply is compared with the image replayed on the data stream. If every byte matches, the run ends with `done`=1 and both error flags at 0.
- R8: At the first reply that differs, the block sets `err_verify`=1 and `fail_addr` = start address + byte offset. It releases chip select, sends no further transfers and ends with `done`=1. `fail_addr` holds its value while idle.
- R9: An image byte is taken only in a cycle where both `data_valid` and `data_ready` are 1. Stalls of any length are tolerated. A clean run takes exactly 2×length bytes.
- R10: `busy` is 1 from the cycle after an accepted start until the run ends, and is never 1 together with `done`. `done` clears when a start is accepted. A `start` pulse while `busy` is ignored.
- R11: `xfer_go` is a one-cycle pulse that occurs only while `spi_cs` is 1. A new one is issued only after `xfer_done` has returned the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse to begin a run (ignored while busy) |
| start_addr | input | 24 | First flash address of the image |
| length | input | 25 | Image length in bytes |
| data_valid | input | 1 | Image byte available |
| data_in | input | 8 | Image byte |
| data_ready | output | 1 | Block takes the image byte this cycle if valid |
| spi_cs | output | 1 | Flash select, 1 = frame active |
| xfer_go | output | 1 | Pulse: SPI master shifts `xfer_tx` |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Pulse: SPI master finished the byte |
| xfer_rx | input | 8 | Byte received during that transfer |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (either outcome) |
| err_id | output | 1 | Identity read back was not the expected value |
| err_verify | output | 1 | Read-back compare failed |
| fail_addr | output | 24 | Address of the first differing byte |

## Verification
The hardest situations to reach are the ones where the record of erased sectors matters. These are a second page that lands in a sector already erased in the same run, a run that crosses a sector boundary, and a later run over a sector that an earlier run already erased. The bench reaches them through address and length choices alone. Its behavioural flash counts erases per sector and flags any program into a sector that has not been erased since its counters were cleared. Another hard case is a compare failure at a chosen offset. The flash model flips one bit of one read reply, so the bench can predict both the reported address and the number of image bytes taken before the block stops.

// File: rtl/nfw_pkg.sv
package nfw_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GAP,
    ST_ID,
    ST_ID_CHK,
    ST_NEXT,
    ST_WREN,
    ST_ERASE,
    ST_PROG,
    ST_POLL,
    ST_VFY,
    ST_FIN
  } seq_st_t;

  function automatic logic is_frame(input seq_st_t s);
    return s inside {ST_ID, ST_WREN, ST_ERASE, ST_PROG, ST_POLL, ST_VFY};
  endfunction

endpackage

// File: rtl/nfw_erase_map.sv
module nfw_erase_map #(
  parameter int NSECT = 64,
  localparam int IW = $clog2(NSECT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set,
  input  logic [IW-1:0] idx,
  output logic          hit
);

  logic [NSECT-1:0] bits;

  for (genvar g = 0; g < NSECT; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)
        bits[g] <= 1'b0;
      else if (set && idx == IW'(g))
        bits[g] <= 1'b1;
    end
  end

  assign hit = bits[idx];

endmodule

// File: rtl/nfw_byte_port.sv
module nfw_byte_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  logic [7:0] tx_in,
  output logic       xfer_go,
  output logic [7:0] xfer_tx,
  input  logic       xfer_done,
  output logic       pend,
  output logic       fin
);

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_go <= 1'b0;
      xfer_tx <= 8'h00;
      pend    <= 1'b0;
    end else begin
      xfer_go <= issue && !pend;
      if (issue && !pend) begin
        pend    <= 1'b1;
        xfer_tx <= tx_in;
      end else if (xfer_done) begin
        pend <= 1'b0;
      end
    end
  end

  assign fin = xfer_done && pend;

endmodule

// File: rtl/nor_flash_writer.sv
module nor_flash_writer
  import nfw_pkg::*;
#(
  parameter int          ADDR_W       = 24,
  parameter int          LEN_W        = 25,
  parameter int          PAGE_BYTES   = 256,
  parameter int          SECTOR_BYTES = 32'h40000,
  parameter int          DEV_BYTES    = 32'h1000000,
  parameter int          ID_W         = 24,
  parameter logic [23:0] EXP_ID       = 24'h202018
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  length,
  input  logic              data_valid,
  input  logic [7:0]        data_in,
  output logic              data_ready,
  output logic              spi_cs,
  output logic              xfer_go,
  output logic [7:0]        xfer_tx,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic              busy,
  output logic              done,
  output logic              err_id,
  output logic              err_verify,
  output logic [ADDR_W-1:0] fail_addr
);

  localparam int SECT_LG = $clog2(SECTOR_BYTES);
  localparam int NSECT   = DEV_BYTES / SECTOR_BYTES;
  localparam int SIDX_W  = $clog2(NSECT);
  localparam int HDR     = 1 + ADDR_W / 8;
  localparam int ID_LEN  = 1 + ID_W / 8;
  localparam int CNT_W   = $clog2(HDR + PAGE_BYTES + 1);
  localparam logic [CNT_W-1:0] C_HDR_LAST = CNT_W'(HDR - 1);
  localparam logic [CNT_W-1:0] C_ID_LAST  = CNT_W'(ID_LEN - 1);
  localparam logic [CNT_W-1:0] C_PG_LAST  = CNT_W'(HDR + PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] C_HDR      = CNT_W'(HDR);

  seq_st_t            st, ret_st, after_wren, after_poll;
  logic [CNT_W-1:0]   bcnt;
  logic [ADDR_W-1:0]  base_addr, cur_addr, voff, fail_q;
  logic [LEN_W-1:0]   len_q, remain;
  logic [ID_W-1:0]    id_sr;
  logic [7:0]         exp_q, tx_sel;
  logic               cs_q, busy_q, done_q, eid_q, ever_q;
  logic               need_data, in_frame, slot_free, issue, pend, fin;
  logic               map_hit, map_set, map_clr;
  logic [SIDX_W-1:0]  sect_idx;

  function automatic logic [7:0] hdr_byte(input logic [7:0] op,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [CNT_W-1:0] i);
    if (i == '0) return op;
    return 8'(a >> (8 * (HDR - 1 - int'(i))));
  endfunction

  assign sect_idx = cur_addr[SECT_LG +: SIDX_W];
  assign in_frame = is_frame(st);

  always_comb begin
    tx_sel    = 8'hFF;
    need_data = 1'b0;
    case (st)
      ST_ID:    if (bcnt == '0) tx_sel = OP_RDID;
      ST_WREN:  tx_sel = OP_WREN;
      ST_POLL:  if (bcnt == '0) tx_sel = OP_RDSR;
      ST_ERASE: tx_sel = hdr_byte(OP_SE, cur_addr, bcnt);
      ST_PROG: begin
        if (bcnt < C_HDR) tx_sel = hdr_byte(OP_PP, cur_addr, bcnt);
        else if (remain != '0) begin
          tx_sel    = data_in;
          need_data = 1'b1;
        end
      end
      ST_VFY: begin
        if (bcnt < C_HDR) tx_sel = hdr_byte(OP_READ, base_addr, bcnt);
        else need_data = 1'b1;
      end
      default: ;
    endcase
  end

  assign slot_free  = in_frame && cs_q && !pend;
  assign data_ready = slot_free && need_data;
  assign issue      = slot_free && (!need_data || data_valid);
  assign map_set    = (st == ST_ERASE) && fin && (bcnt == C_HDR_LAST);
  assign map_clr    = (st == ST_IDLE) && start;

  nfw_byte_port u_port (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .tx_in     (tx_sel),
    .xfer_go   (xfer_go),
    .xfer_tx   (xfer_tx),
    .xfer_done (xfer_done),
    .pend      (pend),
    .fin       (fin)
  );

  nfw_erase_map #(.NSECT(NSECT)) u_map (
    .clk (clk),
    .rst (rst),
    .clr (map_clr),
    .set (map_set),
    .idx (sect_idx),
    .hit (map_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ret_st     <= ST_IDLE;
      after_wren <= ST_IDLE;
      after_poll <= ST_IDLE;
      bcnt       <= '0;
      base_addr  <= '0;
      cur_addr   <= '0;
      voff       <= '0;
      fail_q     <= '0;
      len_q      <= '0;
      remain     <= '0;
      id_sr      <= '0;
      exp_q      <= '0;
      cs_q       <= 1'b0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      eid_q      <= 1'b0;
      ever_q     <= 1'b0;
    end else begin
      if (issue && need_data) begin
        remain <= remain - 1'b1;
        exp_q  <= data_in;
      end
      case (st)
        ST_IDLE: if (start) begin
          base_addr <= start_addr;
          cur_addr  <= start_addr;
          len_q     <= length;
          remain    <= length;
          voff      <= '0;
          fail_q    <= '0;
          busy_q    <= 1'b1;
          done_q    <= 1'b0;
          eid_q     <= 1'b0;
          ever_q    <= 1'b0;
          ret_st    <= ST_ID;
          st        <= ST_GAP;
        end
        ST_GAP: begin
          st   <= ret_st;
          cs_q <= is_frame(ret_st);
          bcnt <= '0;
        end
        ST_ID: if (fin) begin
          if (bcnt != '0) id_sr <= {id_sr[ID_W-9:0], xfer_rx};
          if (bcnt == C_ID_LAST) begin
            cs_q <= 1'b0; ret_st <= ST_ID_CHK; st <= ST_GAP;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_ID_CHK: begin
          if (id_sr == EXP_ID) st <= ST_NEXT;
          else begin
            eid_q <= 1'b1;
            st    <= ST_FIN;
          end
        end
        ST_NEXT: begin
          st <= ST_GAP;
          if (remain == '0) begin
            remain <= len_q;
            ret_st <= ST_VFY;
          end else begin
            after_wren <= map_hit ? ST_PROG : ST_ERASE;
            ret_st     <= ST_WREN;
          end
        end
        ST_WREN: if (fin) begin
          cs_q <= 1'b0; ret_st <= after_wren; st <= ST_GAP;
        end
        ST_ERASE: if (fin) begin
          if (bcnt == C_HDR_LAST) begin
            cs_q       <= 1'b0;
            ret_st     <= ST_POLL;
            st         <= ST_GAP;
            after_poll <= ST_WREN;
            after_wren <= ST_PROG;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_PROG: if (fin) begin
          if (bcnt == C_PG_LAST) begin
            cur_addr   <= cur_addr + ADDR_W'(PAGE_BYTES);
            cs_q       <= 1'b0;
            ret_st     <= ST_POLL;
            st         <= ST_GAP;
            after_poll <= ST_NEXT;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_POLL: if (fin) begin
          if (bcnt != '0) begin
            cs_q   <= 1'b0;
            st     <= ST_GAP;
            ret_st <= xfer_rx[0] ? ST_POLL : after_poll;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_VFY: if (fin) begin
          if (bcnt < C_HDR_LAST) bcnt <= bcnt + 1'b1;
          else if (bcnt == C_HDR_LAST) begin
            if (remain == '0) begin
              cs_q <= 1'b0; st <= ST_FIN;
            end else bcnt <= bcnt + 1'b1;
          end else if (xfer_rx != exp_q) begin
            ever_q <= 1'b1;
            fail_q <= base_addr + voff;
            cs_q   <= 1'b0;
            st     <= ST_FIN;
          end else if (remain == '0) begin
            cs_q <= 1'b0; st <= ST_FIN;
          end else voff <= voff + 1'b1;
        end
        ST_FIN: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs     = cs_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign err_id     = eid_q;
  assign err_verify = ever_q;
  assign fail_addr  = fail_q;

endmodule

// File: rtl/nfw_checker.sv
module nfw_checker (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err_id,
  input logic        err_verify,
  input logic        spi_cs,
  input logic        xfer_go,
  input logic        data_ready,
  input logic [23:0] fail_addr
);

  // R11
  go_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_go |-> spi_cs);

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> !xfer_go);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R10
  start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  // R2
  id_err_ends_chk: assert property (@(posedge clk) disable iff (rst)
    err_id |-> (done || busy) && !err_verify);

  // R9
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    data_ready |-> busy);

  // R8
  fail_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(fail_addr));

endmodule

bind nor_flash_writer nfw_checker u_nfw_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err_id     (err_id),
  .err_verify (err_verify),
  .spi_cs     (spi_cs),
  .xfer_go    (xfer_go),
  .data_ready (data_ready),
  .fail_addr  (fail_addr)
);

// File: tb/tb_nor_flash_writer.sv
module tb_nor_flash_writer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [24:0] length = '0;
  logic        data_valid;
  logic [7:0]  data_in;
  logic        data_ready;
  logic        spi_cs, xfer_go, xfer_done;
  logic [7:0]  xfer_tx, xfer_rx;
  logic        busy, done, err_id, err_verify;
  logic [23:0] fail_addr;

  always #4 clk = ~clk;

  nor_flash_writer dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
    .data_valid(data_valid), .data_in(data_in), .data_ready(data_ready),
    .spi_cs(spi_cs), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx),
    .busy(busy), .done(done), .err_id(err_id), .err_verify(err_verify),
    .fail_addr(fail_addr)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [7:0] img [0:1023];
  int img_len = 1;
  logic log_clr = 1'b0, pre_req = 1'b0;
  int pre_addr = 0;
  logic [7:0] pre_val = 8'h00;
  logic [23:0] dev_id = 24'h202018;
  int corrupt_at = -1;

  // ---------- image source ----------
  int sidx, consumed;
  always @(posedge clk) begin : src_blk
    int nx;
    if (rst || log_clr) begin
      sidx <= 0; consumed <= 0; data_valid <= 1'b0; data_in <= img[0];
    end else begin
      nx = sidx;
      if (data_valid && data_ready) begin
        consumed <= consumed + 1;
        nx = (sidx + 1 >= img_len) ? 0 : sidx + 1;
      end
      sidx <= nx;
      data_in <= img[nx];
      data_valid <= (cyc % 5) != 3;
    end
  end

  // ---------- behavioural flash behind the byte port ----------
  logic [7:0] fmem [int];
  int fidx = 0, fop = 0, faddr = 0, fpg = 0, wip = 0;
  bit wel = 0, seen = 0, mpend = 0, prev_cs = 0;
  int lat = 0;
  logic [7:0] mrx;
  int erase_cnt [64];
  int n_erase, n_prog, n_poll, n_rdata, wren_viol, pad_viol, order_viol, first_op;

  function automatic logic [7:0] frd(input int a);
    return fmem.exists(a) ? fmem[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] respond(input logic [7:0] b);
    logic [7:0] r;
    int pa;
    r = 8'hFF;
    if (fidx == 0) begin
      fop = int'(b); fpg = 0; faddr = 0;
      if (!seen) begin first_op = int'(b); seen = 1; end
      if (b == 8'h06) wel = 1;
      if (b == 8'h05) n_poll++;
    end else if (fidx <= 3 && (fop == 2 || fop == 3 || fop == 'hD8)) begin
      faddr = ((faddr << 8) | int'(b)) & 'hFFFFFF;
    end else if (fop == 'h9F && fidx <= 3) begin
      r = 8'(dev_id >> (8 * (3 - fidx)));
    end else if (fop == 5) begin
      r = {7'd0, wip > 0};
      if (wip > 0) wip--;
    end else if (fop == 3) begin
      r = frd(faddr);
      if (faddr == corrupt_at) r = r ^ 8'h01;
      n_rdata++; faddr++;
    end else if (fop == 2) begin
      pa = (faddr & 'hFFFF00) | ((faddr + fpg) & 'hFF);
      if (fpg == 0 && erase_cnt[pa >> 18] == 0) order_viol++;
      fmem[pa] = frd(pa) & b;
      fpg++;
    end
    fidx++;
    return r;
  endfunction

  function automatic void frame_end();
    int keys[$];
    int s;
    if (fop == 'hD8 && fidx == 4) begin
      if (!wel) wren_viol++;
      s = faddr >> 18;
      erase_cnt[s]++; n_erase++;
      foreach (fmem[k]) if ((k >> 18) == s) keys.push_back(k);
      foreach (keys[i]) fmem.delete(keys[i]);
      wel = 0; wip = 3;
    end else if (fop == 2) begin
      if (!wel) wren_viol++;
      if (fpg != 256) pad_viol++;
      n_prog++; wel = 0; wip = 2;
    end
    fidx = 0; fop = 0;
  endfunction

  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (rst) begin
      mpend = 0; prev_cs = 0; fidx = 0; wel = 0; wip = 0; xfer_rx <= 8'h00;
    end else begin
      if (log_clr) begin
        n_erase = 0; n_prog = 0; n_poll = 0; n_rdata = 0; wren_viol = 0;
        pad_viol = 0; order_viol = 0; first_op = -1; seen = 0;
        for (int i = 0; i < 64; i++) erase_cnt[i] = 0;
      end
      if (pre_req) fmem[pre_addr] = pre_val;
      if (mpend) begin
        if (lat == 0) begin xfer_done <= 1'b1; xfer_rx <= mrx; mpend = 0; end
        else lat = lat - 1;
      end
      if (xfer_go) begin mrx = respond(xfer_tx); mpend = 1; lat = 2; end
      if (prev_cs && !spi_cs) frame_end();
      prev_cs = spi_cs;
    end
  end

  // ---------- watchdog ----------
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run hung (actual cycle %0d, expected < 150000)", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // ---------- helpers ----------
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_log();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic pulse_start(input logic [23:0] a, input int n);
    start_addr = a; length = 25'(n); img_len = n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  function automatic int img_mismatch(input int a, input int n, input int span);
    int bad = 0;
    for (int i = 0; i < span; i++) begin
      if (i < n) begin if (frd(a + i) != img[i]) bad++; end
      else if (frd(a + i) != 8'hFF) bad++;
    end
    return bad;
  endfunction

  // ---------- scenarios ----------
  task automatic t_reset();
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(err_id == 0 && err_verify == 0, "R1", "errors", {err_id, err_verify}, 0);
    chk(spi_cs == 0 && xfer_go == 0, "R1", "cs/go", {spi_cs, xfer_go}, 0);
    chk(data_ready == 0, "R1", "data_ready", data_ready, 0);
  endtask

  task automatic t_bad_id();
    dev_id = 24'h202017;
    clr_log();
    pulse_start(24'h100000, 20);
    wait_done();
    chk(err_id == 1 && err_verify == 0, "R2", "err_id on wrong identity", err_id, 1);
    chk(first_op == 'h9F, "R2", "first opcode", first_op, 'h9F);
    chk(n_erase == 0 && n_prog == 0, "R2", "erase+program count", n_erase + n_prog, 0);
    chk(consumed == 0, "R9", "bytes taken after id error", consumed, 0);
    dev_id = 24'h202018;
  endtask

  task automatic t_basic();
    clr_log();
    pulse_start(24'h100000, 300);
    chk(done == 0 && busy == 1, "R10", "done cleared, busy set", {busy, done}, 2'b10);
    wait_done();
    chk(err_id == 0 && err_verify == 0, "R7", "clean run flags", {err_id, err_verify}, 0);
    chk(erase_cnt[4] == 1 && n_erase == 1, "R4", "erases of sector 4", n_erase, 1);
    chk(order_viol == 0, "R4", "program before erase", order_viol, 0);
    chk(n_prog == 2, "R5", "page program count", n_prog, 2);
    chk(pad_viol == 0, "R5", "frames without 256 data bytes", pad_viol, 0);
    chk(img_mismatch(32'h100000, 300, 512) == 0, "R5", "flash contents + 0xFF pad",
        img_mismatch(32'h100000, 300, 512), 0);
    chk(wren_viol == 0, "R3", "ops without write enable", wren_viol, 0);
    chk(n_poll == 10, "R6", "status polls", n_poll, 10);
    chk(consumed == 600, "R9", "image bytes taken", consumed, 600);
    chk(n_rdata == 300, "R7", "read-back bytes", n_rdata, 300);
  endtask

  task automatic t_cross();
    @(negedge clk) begin pre_addr = 32'h140080; pre_val = 8'h00; pre_req = 1'b1; end
    @(negedge clk) pre_req = 1'b0;
    clr_log();
    pulse_start(24'h13FE00, 700);
    wait_done();
    chk(erase_cnt[4] == 1 && erase_cnt[5] == 1 && n_erase == 2, "R4",
        "erases across sector boundary", n_erase, 2);
    chk(n_prog == 3 && pad_viol == 0, "R5", "programs across boundary", n_prog, 3);
    chk(frd(32'h140080) == img[640], "R4", "stale byte erased then written",
        frd(32'h140080), img[640]);
    chk(frd(32'h1400BC) == 8'hFF && frd(32'h1400FF) == 8'hFF, "R5", "pad after image",
        frd(32'h1400BC), 8'hFF);
    chk(err_verify == 0 && wren_viol == 0, "R3", "boundary run clean",
        {err_verify, 8'(wren_viol)}, 0);
  endtask

  task automatic t_rerun();
    clr_log();
    pulse_start(24'h100000, 300);
    wait_done();
    chk(erase_cnt[4] == 1, "R4", "sector erased again in new run", erase_cnt[4], 1);
    chk(order_viol == 0 && err_verify == 0, "R4", "new run programs erased sector",
        order_viol, 0);
  endtask

  task automatic t_mismatch();
    corrupt_at = 32'h100085;
    clr_log();
    pulse_start(24'h100000, 300);
    wait_done();
    chk(err_verify == 1 && err_id == 0, "R8", "err_verify", err_verify, 1);
    chk(fail_addr == 24'h100085, "R8", "fail_addr", fail_addr, 24'h100085);
    chk(n_rdata == 'h86, "R8", "reads before stop", n_rdata, 'h86);
    chk(consumed == 300 + 'h86, "R9", "bytes taken with early stop", consumed, 300 + 'h86);
    repeat (20) @(negedge clk);
    chk(fail_addr == 24'h100085 && spi_cs == 0, "R8", "fail_addr held idle", fail_addr, 24'h100085);
    corrupt_at = -1;
  endtask

  task automatic t_busy_ignore();
    clr_log();
    pulse_start(24'h100000, 300);
    repeat (40) @(negedge clk);
    chk(busy == 1 && done == 0, "R10", "busy mid-run", busy, 1);
    start_addr = 24'h200000;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done();
    chk(erase_cnt[8] == 0 && n_erase == 1, "R10", "start ignored while busy", erase_cnt[8], 0);
    chk(err_verify == 0 && busy == 0, "R10", "run completes normally", {busy, err_verify}, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) img[i] = 8'(i * 7 + 8'h3C + (i >> 8));
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_bad_id();
    t_basic();
    t_cross();
    t_rerun();
    t_mismatch();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule